// File: doc/BRIEF.md
# Bit-plane SRAM read-back streamer

This block fetches a stored frame from eight serial SPI SRAMs that are one bit wide and share a single chip select, a single clock and a single data-in line. Each SRAM holds one bit plane of the frame. Every clock pulse after the command header makes all eight devices present one bit each. The block gathers those eight bits into one byte and offers it to a downstream byte sink, such as a UART transmitter, over a valid/ready handshake.

A transfer begins with a one-cycle `start_i` pulse. At that point the block latches the base address, the count of leading bytes to drop and the count of bytes to deliver. It lowers chip select and shifts out the sequential read header. It then clocks the SRAMs once per byte and silently drops the first bytes, which hold no picture data. It delivers exactly the requested number of bytes and finishes by raising chip select with the clock parked low. A full frame is 168,960 bytes, so the counters are 18 bits wide by default.

The SRAM clock is generated from the system clock with a programmable half period. It advances only when the sink has taken the previous byte. A slow sink therefore stretches the high phase of the clock, and no byte is lost or repeated.

Top module: `bitplane_readback`

## Requirements
- R1: While reset is high and after it is released, `sram_cs_n_o` is 1, `sram_sck_o`, `sram_si_o`, `byte_valid_o` and `done_o` are 0.
- R2: On an accepted start, `sram_cs_n_o` goes low and 32 header bits are sent on `sram_si_o`, most significant bit first: the read opcode 0x03 followed by the 24-bit base address. The SRAM samples each bit at a rising edge of `sram_sck_o`, and `sram_si_o` changes only while `sram_sck_o` is low.
- R3: While chip select is low, every low phase and every high phase of `sram_sck_o` lasts at least `SCK_HALF` system clocks.
- R4: After the header, each rising edge of `sram_sck_o` produces one byte. All eight `sram_so_i` lines are captured together before the clock falls, and bit i of the byte is `sram_so_i[i]`. `sram_so_i` is ignored during the 32 header clocks.
- R5: The first `skip_cnt_i` bytes read after the header are discarded and never presented on the byte stream.
- R6: Exactly `byte_cnt_i` bytes are presented, in increasing address order. The total number of rising clock edges in the transfer is 32 + skip + count.
- R7: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o` stays high, `byte_data_o` is unchanged and `sram_sck_o` stays high.
- R8: When the last byte is accepted, `sram_sck_o` is lowered. One clock later `sram_cs_n_o` rises and `done_o` is high for exactly one cycle, with the clock low and no byte valid.
- R9: A start pulse, or a change of the base, skip or count inputs, while a transfer is running has no effect on that transfer, and no new transfer follows it.
- R10: With a byte count of zero, only the header is sent (32 clock edges), no byte is presented and `done_o` still pulses, whatever the skip count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a read-back |
| base_addr_i | input | ADDR_W | First SRAM address to read |
| skip_cnt_i | input | CNT_W | Number of leading bytes to drop |
| byte_cnt_i | input | CNT_W | Number of bytes to deliver |
| sram_cs_n_o | output | 1 | Shared active-low SRAM chip select |
| sram_sck_o | output | 1 | Shared SRAM serial clock |
| sram_si_o | output | 1 | Shared SRAM serial data in (header) |
| sram_so_i | input | LANES | Serial data out, one line per SRAM bit plane |
| byte_data_o | output | LANES | Rebuilt byte |
| byte_valid_o | output | 1 | Byte is offered to the sink |
| byte_ready_i | input | 1 | Sink accepts the offered byte |
| done_o | output | 1 | One-cycle pulse at end of transfer |

## Verification
In the header, the SRAM clock rises `SCK_HALF` cycles after chip select falls and then toggles every `SCK_HALF` cycles. A byte becomes valid on the edge that ends the high phase, `SCK_HALF` cycles after its rising clock edge. The clock falls on the edge that takes the byte, and `done_o` follows one cycle after the final byte is taken. The bench drives all inputs and samples all outputs on the falling system clock edge, so each of these results is observed in the cycle it becomes due. An SRAM model reacts to the real clock edges to rebuild the header and to feed address-derived data onto the eight lanes. Stall, phase-length and done conditions are checked at every falling edge and summed over each transfer.

// File: rtl/br_pkg.sv
`timescale 1ns/1ps
package br_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_LO,
    ST_HDR_HI,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_DAT_OUT,
    ST_FINISH
  } br_state_e;

  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] BR_READ_OP = 8'h03;
endpackage

// File: rtl/br_phase_timer.sv
`timescale 1ns/1ps
// Counts system clocks within one SRAM clock phase; tick marks the last one.
module br_phase_timer #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/br_hdr_shift.sv
`timescale 1ns/1ps
// Holds the read command and address; the top bit drives the serial line.
module br_hdr_shift
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              bit_o
);
  localparam int unsigned HW = OP_W + ADDR_W;

  logic [HW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (load_i)  sr_q <= {BR_READ_OP, addr_i};
    else if (shift_i) sr_q <= {sr_q[HW-2:0], 1'b0};
  end

  assign bit_o = sr_q[HW-1];
endmodule

// File: rtl/br_xfer_count.sv
`timescale 1ns/1ps
// Remaining bytes to drop and to deliver for the running transfer.
module br_xfer_count #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] skip_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             skip_dec_i,
  input  logic             byte_dec_i,
  output logic             skip_zero_o,
  output logic             left_zero_o,
  output logic             left_one_o
);
  logic [CNT_W-1:0] skip_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      skip_q <= skip_i;
      left_q <= count_i;
    end else begin
      if (skip_dec_i) skip_q <= skip_q - 1'b1;
      if (byte_dec_i) left_q <= left_q - 1'b1;
    end
  end

  assign skip_zero_o = (skip_q == '0);
  assign left_zero_o = (left_q == '0);
  assign left_one_o  = (left_q == CNT_W'(1));
endmodule

// File: rtl/br_lane_gather.sv
`timescale 1ns/1ps
// Captures one bit from every plane at once; bit i comes from lane i.
module br_lane_gather #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [LANES-1:0] lanes_i,
  output logic [LANES-1:0] byte_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_o <= '0;
    end else if (cap_i) begin
      for (int i = 0; i < LANES; i++) byte_o[i] <= lanes_i[i];
    end
  end
endmodule

// File: rtl/bitplane_readback.sv
`timescale 1ns/1ps
module bitplane_readback
  import br_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned CNT_W    = 18,
  parameter int unsigned SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  skip_cnt_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic              sram_cs_n_o,
  output logic              sram_sck_o,
  output logic              sram_si_o,
  input  logic [LANES-1:0]  sram_so_i,
  output logic [LANES-1:0]  byte_data_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic              done_o
);
  localparam int unsigned HW  = OP_W + ADDR_W;
  localparam int unsigned HCW = $clog2(HW);
  localparam logic [HCW-1:0] HDR_LAST = HCW'(HW - 1);

  br_state_e      state;
  logic [HCW-1:0] hdr_idx;
  logic           cs_n_q, sck_q, valid_q, done_q;
  logic           run, tick, load, shift, cap, skip_dec, byte_dec;
  logic           skip_zero, left_zero, left_one, hdr_last;

  assign run = (state == ST_HDR_LO) || (state == ST_HDR_HI) ||
               (state == ST_DAT_LO) || (state == ST_DAT_HI);
  assign load     = (state == ST_IDLE) && start_i;
  assign shift    = (state == ST_HDR_HI) && tick;
  assign cap      = (state == ST_DAT_HI) && tick;
  assign skip_dec = cap && !skip_zero;
  assign byte_dec = (state == ST_DAT_OUT) && byte_ready_i;
  assign hdr_last = (hdr_idx == HDR_LAST);

  br_phase_timer #(.HALF(SCK_HALF)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .tick_o(tick)
  );

  br_hdr_shift #(.ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst(rst), .load_i(load), .addr_i(base_addr_i),
    .shift_i(shift), .bit_o(sram_si_o)
  );

  br_xfer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .skip_i(skip_cnt_i),
    .count_i(byte_cnt_i), .skip_dec_i(skip_dec), .byte_dec_i(byte_dec),
    .skip_zero_o(skip_zero), .left_zero_o(left_zero), .left_one_o(left_one)
  );

  br_lane_gather #(.LANES(LANES)) u_gather (
    .clk(clk), .rst(rst), .cap_i(cap), .lanes_i(sram_so_i),
    .byte_o(byte_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      hdr_idx <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          cs_n_q  <= 1'b0;
          hdr_idx <= '0;
          state   <= ST_HDR_LO;
        end
        ST_HDR_LO: if (tick) begin
          sck_q <= 1'b1;
          state <= ST_HDR_HI;
        end
        ST_HDR_HI: if (tick) begin
          sck_q <= 1'b0;
          if (hdr_last) begin
            state <= left_zero ? ST_FINISH : ST_DAT_LO;
          end else begin
            hdr_idx <= hdr_idx + 1'b1;
            state   <= ST_HDR_LO;
          end
        end
        ST_DAT_LO: if (tick) begin
          sck_q <= 1'b1;
          state <= ST_DAT_HI;
        end
        ST_DAT_HI: if (tick) begin
          if (skip_zero) begin
            valid_q <= 1'b1;
            state   <= ST_DAT_OUT;
          end else begin
            sck_q <= 1'b0;
            state <= ST_DAT_LO;
          end
        end
        ST_DAT_OUT: if (byte_ready_i) begin
          valid_q <= 1'b0;
          sck_q   <= 1'b0;
          state   <= left_one ? ST_FINISH : ST_DAT_LO;
        end
        ST_FINISH: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sram_cs_n_o  = cs_n_q;
  assign sram_sck_o   = sck_q;
  assign byte_valid_o = valid_q;
  assign done_o       = done_q;
endmodule

// File: rtl/br_chk.sv
`timescale 1ns/1ps
module br_chk #(
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sck,
  input logic             si,
  input logic             valid,
  input logic             ready,
  input logic [LANES-1:0] data,
  input logic             done
);
  // R1, R8: the clock is parked low whenever chip select is high
  a_r8_clock_parked: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  // R2: data-in is settled when the clock rises
  a_r2_si_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(si));

  // R7: a refused byte is held along with the high clock
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && sck && $stable(data)));

  // R4: a byte is offered only inside a transfer with the clock high
  a_r4_valid_in_xfer: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!cs_n && sck));

  // R8: done comes with chip select high, clock low, nothing valid
  a_r8_done_parked: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !sck && !valid));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind bitplane_readback br_chk #(.LANES(LANES)) u_br_chk (
  .clk(clk), .rst(rst), .cs_n(sram_cs_n_o), .sck(sram_sck_o),
  .si(sram_si_o), .valid(byte_valid_o), .ready(byte_ready_i),
  .data(byte_data_o), .done(done_o)
);

// File: tb/test_bitplane_readback.sv
`timescale 1ns/1ps
module test_bitplane_readback;
  localparam int LANES = 8, ADDR_W = 24, CNT_W = 18, HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [CNT_W-1:0]  skip_cnt = '0;
  logic [CNT_W-1:0]  byte_cnt = '0;
  logic cs_n, sck, si, valid, done;
  logic [LANES-1:0] so_m = '0;
  logic [LANES-1:0] data;
  logic ready = 1'b0;

  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  bitplane_readback #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
                      .SCK_HALF(HALF)) i_bitplane_readback (
    .clk(clk), .rst(rst), .start_i(start), .base_addr_i(base_addr),
    .skip_cnt_i(skip_cnt), .byte_cnt_i(byte_cnt), .sram_cs_n_o(cs_n),
    .sram_sck_o(sck), .sram_si_o(si), .sram_so_i(so_m),
    .byte_data_o(data), .byte_valid_o(valid), .byte_ready_i(ready),
    .done_o(done)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // SRAM bank model: header bits at rising edges, then one byte per edge
  int edge_cnt = 0, last_edges = 0;
  logic [31:0] hdr_cap = '0;
  always @(posedge sck) begin
    if (!cs_n) begin
      edge_cnt = edge_cnt + 1;
      if (edge_cnt <= 32) hdr_cap = {hdr_cap[30:0], si};
      else so_m = pat(hdr_cap[23:0] + 24'(edge_cnt - 33));
    end
  end
  always @(posedge cs_n) begin
    last_edges = edge_cnt;
    edge_cnt = 0;
  end

  // Sink and per-cycle monitors, all on the falling edge
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] rx_mem [0:1023];
  int rx_n = 0, done_cnt = 0, done_bad = 0, stall_viol = 0, phase_viol = 0;
  bit stall_pend = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_sck = 1'b0;
  int run_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (stall_pend && !(valid && sck && data == prev_data)) stall_viol++;
      if (done) begin
        done_cnt++;
        if (!(cs_n && !sck && !valid)) done_bad++;
      end
      if (cs_n) run_len = 0;
      else if (sck == prev_sck) run_len++;
      else begin
        if (run_len < HALF) phase_viol++;
        run_len = 1;
      end
      prev_sck = sck;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0: ready = 1'b1;
        1: ready = lfsr[0];
        default: ready = lfsr[0] & lfsr[3];
      endcase
      if (valid && ready && rx_n < 1024) begin
        rx_mem[rx_n] = data;
        rx_n++;
      end
      stall_pend = valid && !ready;
      prev_data = data;
    end
  end

  // One transfer with all its checks; poke restarts it with other inputs
  task automatic run_xfer(input logic [23:0] addr, input int skip,
                          input int cnt, input int mode, input bit poke,
                          input string name);
    int rx0 = rx_n, d0 = done_cnt, db0 = done_bad;
    int sv0 = stall_viol, pv0 = phase_viol, bad = 0, w = 0;
    ready_mode = mode;
    @(negedge clk);
    base_addr = addr; skip_cnt = CNT_W'(skip); byte_cnt = CNT_W'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == d0 && w < 20000) begin
      @(negedge clk);
      w++;
      if (poke) begin
        start = (w == 30);
        base_addr = ~addr; skip_cnt = '0; byte_cnt = CNT_W'(3);
      end
    end
    start = 1'b0;
    check(done_cnt == d0 + 1, "R8", {name, " done pulses"}, done_cnt - d0, 1);
    check(done_bad == db0, "R8", {name, " done state"}, done_bad - db0, 0);
    check(hdr_cap == {8'h03, addr}, "R2", {name, " header"},
          int'(hdr_cap), int'({8'h03, addr}));
    check(rx_n - rx0 == cnt, "R6", {name, " byte count"}, rx_n - rx0, cnt);
    check(last_edges == 32 + (cnt == 0 ? 0 : skip) + cnt, "R6",
          {name, " clock edges"}, last_edges,
          32 + (cnt == 0 ? 0 : skip) + cnt);
    for (int k = 0; k < cnt && rx0 + k < rx_n; k++)
      if (rx_mem[rx0 + k] != pat(addr + 24'(skip + k))) bad++;
    check(bad == 0, "R4", {name, " byte values"}, bad, 0);
    if (cnt > 0 && rx_n > rx0)
      check(rx_mem[rx0] == pat(addr + 24'(skip)), "R5", {name, " first kept byte"},
            int'(rx_mem[rx0]), int'(pat(addr + 24'(skip))));
    check(phase_viol == pv0, "R3", {name, " short clock phases"},
          phase_viol - pv0, 0);
    check(stall_viol == sv0, "R7", {name, " stall hold"}, stall_viol - sv0, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      check(cs_n == 1'b1 && rx_n - rx0 == cnt, "R9", {name, " no restart"},
            rx_n - rx0, cnt);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sck === 1'b0 && si === 1'b0 &&
          valid === 1'b0 && done === 1'b0, "R1", "outputs in reset",
          int'({cs_n, sck, si, valid, done}), 16);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sck === 1'b0 && valid === 1'b0 && done === 1'b0,
          "R1", "outputs after reset", int'({cs_n, sck, valid, done}), 8);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    test_reset();
    run_xfer(24'h000010, 0, 8, 0, 1'b0, "plain");                  // R2 R4 R6
    run_xfer(24'h12AB40, 5, 12, 1, 1'b0, "skip+stall");           // R5 R7
    run_xfer(24'h00ABCD, 4, 0, 0, 1'b0, "zero count");            // R10
    run_xfer(24'h345600, 2, 20, 1, 1'b1, "start while busy");     // R9
    run_xfer(24'hFFFFF0, 3, 300, 2, 1'b0, "long wrap heavy stall"); // R3 R7
    run_xfer(24'h0F0F0F, 0, 1, 0, 1'b0, "single byte");           // R8
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule